// File: doc/BRIEF.md
# DMA Task Debug Breakpoint Unit

This block watches a multi-task DMA engine and stops chosen tasks when a programmed condition is seen. Software loads two comparator values and a control word through a small register port. Every cycle, each comparator checks either the observed address stream or the observed data stream against its stored value. The control word picks which stream each comparator uses. The two results are merged with OR or AND. When breakpoints are enabled and the merged result is true, a sticky triggered flag is set. A halt line is then raised for every task whose bit in the control word's task mask is set.

Software clears the triggered flag by writing a one to the status register. The flag can also re-arm itself on its own. If the auto re-arm bit is set, the flag drops one cycle after the engine reports, through a strobe, that it has saved the halted task's context. The engine and its context-save logic sit outside this block. The bench plays their part.

Top module: `dma_brk_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, the control word, both comparator values and the triggered flag are 0. `bp_triggered` is 0, `task_halt` is 0, and every register reads 0.
- R2: Register address 0 is control, 1 is comparator A value, 2 is comparator B value and 3 is status. Status bit 0 reads the triggered flag. In the control word, bit 0 selects the combine mode, bit 1 is the breakpoint enable and bit 2 is auto re-arm. Bits 6:4 hold comparator A's kind, bits 10:8 hold comparator B's kind and bits 31:16 hold the task mask. All other bits read 0. A write takes effect at the clock edge and read data is combinational.
- R3: A comparator of kind 0 matches when `obs_addr_vld` is 1 and `obs_addr` equals its value. Kind 1 matches when `obs_data_vld` is 1 and `obs_data` equals its value. Kinds 2 to 7 never match.
- R4: With control bit 0 at 0, the merged match is the OR of the two comparator matches. With bit 0 at 1, it is their AND.
- R5: With the enable bit (control bit 1) at 0, the triggered flag is never set.
- R6: When the flag is clear, enable is 1 and the merged match is true in a cycle, `bp_triggered` is 1 after that cycle's clock edge. It then stays 1 until a clear, and further matches have no effect.
- R7: `task_halt[i]` equals control bit 16+i ANDed with the triggered flag, so control bit 31 halts task 15 and bit 16 halts task 0.
- R8: Writing status with bit 0 at 1 clears the triggered flag at that edge. Writing status with bit 0 at 0 leaves it unchanged.
- R9: With auto re-arm at 1, if `ctx_save_done` is high in cycle k, the flag is 0 after the edge ending cycle k+1. With auto re-arm at 0, the strobe has no effect.
- R10: A clear, whether by software or by auto re-arm, wins over a match in the same cycle. A match in a later cycle sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_addr` |
| obs_addr_vld | input | 1 | Observed address is valid |
| obs_addr | input | DATA_W | Observed address |
| obs_data_vld | input | 1 | Observed data is valid |
| obs_data | input | DATA_W | Observed data |
| ctx_save_done | input | 1 | Context save finished strobe |
| bp_triggered | output | 1 | Sticky triggered flag |
| task_halt | output | NUM_TASKS | Per-task halt request |

## Verification
The bench builds the unit with its defaults: 16 tasks and 32-bit values. These place the task mask in the full upper half of the control word, so the top task sits at bit 31. Random 32-bit traffic would almost never equal a comparator value. The bench therefore steers the address and data streams toward the loaded values, which keeps AND, OR and kind combinations firing often. Random writes to the status register and the context-save strobe land on triggered cycles often enough to reach clear-versus-match collisions and both auto re-arm settings.

// File: rtl/dbgbp_pkg.sv
// Package dbgbp_pkg
// Shared field positions, register addresses and the control-word record for
// the DMA task breakpoint unit. Assumes a data width of at least 32 bits.
package dbgbp_pkg;

    localparam int MASK_W   = 16;
    localparam int KIND_W   = 3;

    localparam int BIT_AND  = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_AUTO = 2;
    localparam int KA_LSB   = 4;
    localparam int KB_LSB   = 8;
    localparam int MASK_LSB = 16;

    localparam logic [1:0] RA_CTL  = 2'd0;
    localparam logic [1:0] RA_VALA = 2'd1;
    localparam logic [1:0] RA_VALB = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam logic [KIND_W-1:0] KIND_ADDR = 3'd0;
    localparam logic [KIND_W-1:0] KIND_DATA = 3'd1;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [KIND_W-1:0] kind_b;
        logic [KIND_W-1:0] kind_a;
        logic              auto_arm;
        logic              enable;
        logic              and_sel;
    } ctl_t;

endpackage

// File: rtl/dbgbp_regs.sv
// Module dbgbp_regs
// Holds the control word and the two comparator values, serves reads, and
// turns a status write with bit 0 set into a one-cycle clear pulse.
// Assumes DATA_W >= 32; reserved control bits are dropped on write.
module dbgbp_regs
    import dbgbp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] val_a,
    output logic [DATA_W-1:0] val_b,
    output logic [DATA_W-1:0] rdata,
    output logic              sw_clr
);

    localparam logic [DATA_W-1:0] CTL_USED =
        DATA_W'(32'hFFFF_0777);

    ctl_t ctl_q;
    logic [DATA_W-1:0] va_q, vb_q, ctl_word;

    // Register storage: reset to zero, load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            va_q  <= '0;
            vb_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTL: begin
                    ctl_q.and_sel  <= wdata[BIT_AND];
                    ctl_q.enable   <= wdata[BIT_EN];
                    ctl_q.auto_arm <= wdata[BIT_AUTO];
                    ctl_q.kind_a   <= wdata[KA_LSB +: KIND_W];
                    ctl_q.kind_b   <= wdata[KB_LSB +: KIND_W];
                    ctl_q.mask     <= wdata[MASK_LSB +: MASK_W];
                end
                RA_VALA: va_q <= wdata;
                RA_VALB: vb_q <= wdata;
                default: ;
            endcase
        end
    end

    // Pack the control record back into its word layout for reads.
    always_comb begin
        ctl_word = '0;
        ctl_word[BIT_AND]              = ctl_q.and_sel;
        ctl_word[BIT_EN]               = ctl_q.enable;
        ctl_word[BIT_AUTO]             = ctl_q.auto_arm;
        ctl_word[KA_LSB +: KIND_W]     = ctl_q.kind_a;
        ctl_word[KB_LSB +: KIND_W]     = ctl_q.kind_b;
        ctl_word[MASK_LSB +: MASK_W]   = ctl_q.mask;
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            RA_CTL:  rdata = ctl_word;
            RA_VALA: rdata = va_q;
            RA_VALB: rdata = vb_q;
            default: rdata = {{(DATA_W-1){1'b0}}, trig};
        endcase
    end

    // Software clear pulse from a status write.
    assign sw_clr = wr_en && (addr == RA_STAT) && wdata[0];

    assign ctl   = ctl_q;
    assign val_a = va_q;
    assign val_b = vb_q;

    // Reserved control bits never read back as one.
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == RA_CTL) |-> ((rdata & ~CTL_USED) == '0));

    // A value write is visible on the following cycle.
    assert_vala_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_VALA) |=> (val_a == $past(wdata)));

endmodule

// File: rtl/dbgbp_cmp.sv
// Module dbgbp_cmp
// One comparator: matches its value against the address stream (kind 0) or the
// data stream (kind 1), qualified by the stream's valid. Other kinds never
// match. Purely combinational; the clock only feeds the local assertion.
module dbgbp_cmp
    import dbgbp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] kind,
    input  logic [DATA_W-1:0] value,
    input  logic              a_vld,
    input  logic [DATA_W-1:0] a_bus,
    input  logic              d_vld,
    input  logic [DATA_W-1:0] d_bus,
    output logic              hit
);

    logic eq_a, eq_d;

    // Equality against each observed stream.
    assign eq_a = a_vld && (a_bus == value);
    assign eq_d = d_vld && (d_bus == value);

    // Kind decode selects which stream counts.
    always_comb begin
        case (kind)
            KIND_ADDR: hit = eq_a;
            KIND_DATA: hit = eq_d;
            default:   hit = 1'b0;
        endcase
    end

    // Unsupported kinds never produce a match.
    assert_bad_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind > KIND_DATA) |-> !hit);

    // An address kind ignores the data stream.
    assert_addr_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_ADDR && !a_vld) |-> !hit);

endmodule

// File: rtl/dbgbp_trig.sv
// Module dbgbp_trig
// Merges two comparator matches (OR or AND), gates with enable, and keeps the
// sticky triggered flag. Clears come from software or from auto re-arm one
// cycle after the context-save strobe; a clear wins over a same-cycle match.
module dbgbp_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_a,
    input  logic hit_b,
    input  logic and_sel,
    input  logic enable,
    input  logic auto_arm,
    input  logic ctx_done,
    input  logic sw_clr,
    output logic trig
);

    logic merged, fire, done_d, auto_clr, clr, trig_q;

    // Combine comparator results and gate with the enable.
    assign merged = and_sel ? (hit_a & hit_b) : (hit_a | hit_b);
    assign fire   = enable & merged;

    // Delay the context-save strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_d <= 1'b0;
        else        done_d <= ctx_done;
    end

    assign auto_clr = auto_arm & done_d;
    assign clr      = sw_clr | auto_clr;

    // Sticky flag: set on fire when clear, drop on any clear when set.
    always_ff @(posedge clk) begin
        if (!rst_n)      trig_q <= 1'b0;
        else if (trig_q) trig_q <= ~clr;
        else             trig_q <= fire;
    end

    assign trig = trig_q;

    assert_no_fire_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !enable) |=> !trig);

    assert_and_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && and_sel && !(hit_a && hit_b)) |=> !trig);

    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && enable && (hit_a || hit_b) && !and_sel) |=> trig);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !sw_clr && !(auto_arm && done_d)) |=> trig);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && sw_clr) |=> !trig);

    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && auto_arm && done_d) |=> !trig);

endmodule

// File: rtl/dma_brk_unit.sv
// Module dma_brk_unit
// Top of the DMA task breakpoint unit: register block, two comparators built
// by a generate loop, trigger logic, and per-task halt gating. Assumes
// NUM_TASKS <= 16 and DATA_W >= 32.
module dma_brk_unit
    import dbgbp_pkg::*;
#(
    parameter int NUM_TASKS = 16,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 obs_addr_vld,
    input  logic [DATA_W-1:0]    obs_addr,
    input  logic                 obs_data_vld,
    input  logic [DATA_W-1:0]    obs_data,
    input  logic                 ctx_save_done,
    output logic                 bp_triggered,
    output logic [NUM_TASKS-1:0] task_halt
);

    localparam int NUM_CMP = 2;

    ctl_t              ctl;
    logic [DATA_W-1:0] val_a, val_b;
    logic              sw_clr, trig;
    logic [KIND_W-1:0] cmp_kind [NUM_CMP];
    logic [DATA_W-1:0] cmp_val  [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_hit;

    dbgbp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .trig   (trig),
        .ctl    (ctl),
        .val_a  (val_a),
        .val_b  (val_b),
        .rdata  (cfg_rdata),
        .sw_clr (sw_clr)
    );

    // Route per-comparator kind and value.
    assign cmp_kind[0] = ctl.kind_a;
    assign cmp_kind[1] = ctl.kind_b;
    assign cmp_val[0]  = val_a;
    assign cmp_val[1]  = val_b;

    // One comparator per configured slot.
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        dbgbp_cmp #(.DATA_W(DATA_W)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .kind  (cmp_kind[c]),
            .value (cmp_val[c]),
            .a_vld (obs_addr_vld),
            .a_bus (obs_addr),
            .d_vld (obs_data_vld),
            .d_bus (obs_data),
            .hit   (cmp_hit[c])
        );
    end

    dbgbp_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_a    (cmp_hit[0]),
        .hit_b    (cmp_hit[1]),
        .and_sel  (ctl.and_sel),
        .enable   (ctl.enable),
        .auto_arm (ctl.auto_arm),
        .ctx_done (ctx_save_done),
        .sw_clr   (sw_clr),
        .trig     (trig)
    );

    // Per-task halt: mask bit i gates task i with the triggered flag.
    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_halt
        assign task_halt[t] = ctl.mask[t] & trig;
    end

    assign bp_triggered = trig;

    assert_idle_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_triggered |-> (task_halt == '0));

    assert_halt_in_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (task_halt & ~cfg_rdata[MASK_LSB +: NUM_TASKS] & {NUM_TASKS{cfg_addr == RA_CTL}}) == '0);

endmodule

// File: tb/dma_brk_unit_test.sv
module dma_brk_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] USED = 32'hFFFF_0777;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        obs_addr_vld = 1'b0;
    logic [31:0] obs_addr = '0;
    logic        obs_data_vld = 1'b0;
    logic [31:0] obs_data = '0;
    logic        ctx_save_done = 1'b0;
    logic        bp_triggered;
    logic [15:0] task_halt;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_ctl = '0, m_va = '0, m_vb = '0;
    logic        m_trig = 1'b0, m_done_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_brk_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .obs_addr_vld(obs_addr_vld), .obs_addr(obs_addr),
        .obs_data_vld(obs_data_vld), .obs_data(obs_data),
        .ctx_save_done(ctx_save_done), .bp_triggered(bp_triggered),
        .task_halt(task_halt)
    );

    function automatic logic m_hit(input logic [2:0] kind, input logic [31:0] v);
        if (kind == 3'd0) return obs_addr_vld && obs_addr == v;
        if (kind == 3'd1) return obs_data_vld && obs_data == v;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_ctl;
            2'd1: return m_va;
            2'd2: return m_vb;
            default: return {31'b0, m_trig};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: inputs already driven; advance model and design, compare.
    task automatic step(input string req);
        logic ha, hb, comb, fire, clr, nt;
        ha   = m_hit(m_ctl[6:4], m_va);
        hb   = m_hit(m_ctl[10:8], m_vb);
        comb = m_ctl[0] ? (ha & hb) : (ha | hb);
        fire = m_ctl[1] & comb;
        clr  = (cfg_wr && cfg_addr == 2'd3 && cfg_wdata[0]) || (m_ctl[2] && m_done_d);
        nt   = m_trig ? !clr : fire;
        @(posedge clk);
        m_trig   = nt;
        m_done_d = ctx_save_done;
        if (cfg_wr) begin
            case (cfg_addr)
                2'd0: m_ctl = cfg_wdata & USED;
                2'd1: m_va  = cfg_wdata;
                2'd2: m_vb  = cfg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(req, {31'b0, bp_triggered}, {31'b0, m_trig});
        chk("R7", {16'b0, task_halt}, {16'b0, m_ctl[31:16] & {16{m_trig}}});
        chk("R2", cfg_rdata, m_rdata(cfg_addr));
    endtask

    task automatic drive(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                         input logic av, input logic [31:0] ab,
                         input logic dv, input logic [31:0] db, input logic done);
        cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
        obs_addr_vld = av; obs_addr = ab;
        obs_data_vld = dv; obs_data = db;
        ctx_save_done = done;
    endtask

    task automatic idle(input string req);
        drive(1'b0, 2'd3, '0, 1'b0, '0, 1'b0, '0, 1'b0);
        step(req);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d, input string req);
        drive(1'b1, a, d, 1'b0, '0, 1'b0, '0, 1'b0);
        step(req);
    endtask

    localparam logic [31:0] VA = 32'h1000_0040;
    localparam logic [31:0] VB = 32'hDEAD_BEEF;

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {31'b0, bp_triggered}, 32'd0);
        chk("R1", {16'b0, task_halt}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            cfg_addr = 2'(a);
            #1 chk("R1", cfg_rdata, 32'd0);
        end
        rst_n = 1'b1;

        // R2: values and reserved-bit masking
        wreg(2'd1, VA, "R2");
        wreg(2'd2, VB, "R2");
        wreg(2'd0, 32'hFFFF_FFFF, "R2");
        chk("R2", cfg_rdata & ~USED, 32'd0);
        // OR, enable, kind A addr, kind B data, mask only top bit (task 15)
        wreg(2'd0, 32'h8000_0102, "R2");
        // R3: address match on comparator A sets the flag (R6)
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b0, '0, 1'b0); step("R3");
        chk("R7", {16'b0, task_halt}, 32'h0000_8000);
        // R6: sticky with no match and with further matches
        idle("R6"); idle("R6");
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b1, VB, 1'b0); step("R6");
        // R8: writing 0 does nothing, writing 1 clears
        wreg(2'd3, 32'hFFFF_FFFE, "R8");
        chk("R8", {31'b0, bp_triggered}, 32'd1);
        wreg(2'd3, 32'd1, "R8");
        chk("R8", {31'b0, bp_triggered}, 32'd0);
        // R9 off: strobe has no effect without auto re-arm
        drive(1'b0, 2'd3, '0, 1'b0, '0, 1'b1, VB, 1'b0); step("R3");
        drive(1'b0, 2'd3, '0, 1'b0, '0, 1'b0, '0, 1'b1); step("R9");
        idle("R9"); idle("R9");
        chk("R9", {31'b0, bp_triggered}, 32'd1);
        wreg(2'd3, 32'd1, "R8");
        // R5: enable off, match present
        wreg(2'd0, 32'h0001_0100, "R5");
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b1, VB, 1'b0); step("R5");
        chk("R5", {31'b0, bp_triggered}, 32'd0);
        // R4: AND mode, one side only, then both; mask bit 16 -> task 0
        wreg(2'd0, 32'h0001_0103, "R4");
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b0, '0, 1'b0); step("R4");
        chk("R4", {31'b0, bp_triggered}, 32'd0);
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b1, VB, 1'b0); step("R4");
        chk("R4", {31'b0, bp_triggered}, 32'd1);
        chk("R7", {16'b0, task_halt}, 32'h0000_0001);
        wreg(2'd3, 32'd1, "R8");
        // R3: kinds 2 and 7 never match
        wreg(2'd0, 32'hFFFF_0722, "R3");
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b1, VB, 1'b0); step("R3");
        drive(1'b0, 2'd3, '0, 1'b1, VB, 1'b1, VA, 1'b0); step("R3");
        chk("R3", {31'b0, bp_triggered}, 32'd0);
        // R9: auto re-arm drops one cycle after the strobe
        wreg(2'd0, 32'hA5A5_0106, "R9");
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b0, '0, 1'b0); step("R6");
        drive(1'b0, 2'd3, '0, 1'b0, '0, 1'b0, '0, 1'b1); step("R9");
        chk("R9", {31'b0, bp_triggered}, 32'd1);
        idle("R9");
        chk("R9", {31'b0, bp_triggered}, 32'd0);
        // R10: clear wins over a same-cycle match, next match re-sets
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b0, '0, 1'b0); step("R6");
        drive(1'b1, 2'd3, 32'd1, 1'b1, VA, 1'b0, '0, 1'b0); step("R10");
        chk("R10", {31'b0, bp_triggered}, 32'd0);
        drive(1'b0, 2'd3, '0, 1'b1, VA, 1'b0, '0, 1'b0); step("R10");
        chk("R10", {31'b0, bp_triggered}, 32'd1);

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic wr;
            logic [1:0] a;
            logic [31:0] wd, ab, db;
            wr = ($urandom % 6) == 0;
            a  = 2'($urandom % 4);
            wd = $urandom;
            if (a == 2'd0) begin
                wd[6:4]  = 3'($urandom % 4);
                wd[10:8] = 3'($urandom % 4);
                if (($urandom % 4) != 0) wd[1] = 1'b1;
            end
            if (a == 2'd1 || a == 2'd2) wd = (($urandom % 2) == 0) ? VA : VB;
            case ($urandom % 3)
                0: ab = m_va;
                1: ab = m_vb;
                default: ab = $urandom;
            endcase
            case ($urandom % 3)
                0: db = m_vb;
                1: db = m_va;
                default: db = $urandom;
            endcase
            drive(wr, a, wd, 1'($urandom % 2), ab, 1'($urandom % 2), db,
                  ($urandom % 6) == 0);
            step("R6");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule